// File: doc/BRIEF.md
# ASID-Tagged Address Translation Buffer

This block is a small fully associative translation buffer. Every cycle it takes a 32-bit virtual address and the current 8-bit address-space identifier. It searches all of its entries at once. One clock later it reports one of two results:

- a hit, with the 32-bit physical address and the entry's cacheability attribute;
- a miss, so that software can refill the buffer.

Each entry can map either a 4-Kbyte page or a 16-Mbyte page. The page size sets how many upper address bits take part in the comparison and how many low bits pass through untranslated. An entry can also be marked global, so that it matches whatever the current identifier is.

Software loads entries one at a time through a write port addressed by index. The entry count and the field widths are constants of the shared package.

Top module: `tlb_xlate`

## Requirements
- R1: While rstN is low all outputs are 0. Reset leaves every entry invalid, so every lookup misses until an entry with wrValid=1 has been written.
- R2: An entry marked as a 4-Kbyte page (big=0) needs its 20-bit page number to equal vaddr[31:12].
- R3: A matching entry also needs either its global bit set or its stored identifier equal to the asid input.
- R4: An entry marked as a 16-Mbyte page (big=1) compares only page-number bits [19:12] with vaddr[31:24]. On a hit, outPaddr is {pfn[19:12], vaddr[23:0]}.
- R5: On a hit through a 4-Kbyte entry, outPaddr is {pfn[19:0], vaddr[11:0]}.
- R6: On a hit, outCached equals the cached bit of the winning entry.
- R7: When no entry matches, outMiss is 1 while outHit, outMulti, outCached and outPaddr are 0. Otherwise outHit is 1 and outMiss is 0.
- R8: When several entries match, the entry with the lowest index wins and outMulti is 1. With a single match outMulti is 0.
- R9: Outputs are registered: they reflect the inputs of the previous clock cycle. A write takes effect at the clock edge, so a lookup in the same cycle as a write still sees the old contents.
- R10: Writing an index with wrValid=0 invalidates that entry, so it no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vaddr | input | 32 | Virtual address to translate |
| asid | input | 8 | Current address-space identifier |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 4 | Index of the entry to write |
| wrValid | input | 1 | Valid bit written into the entry |
| wrVpn | input | 20 | Virtual page number of the entry |
| wrAsid | input | 8 | Identifier stored with the entry |
| wrGlobal | input | 1 | Entry matches under any identifier |
| wrBig | input | 1 | 1 = 16-Mbyte page, 0 = 4-Kbyte page |
| wrPfn | input | 20 | Physical frame number |
| wrCached | input | 1 | Cacheability attribute of the entry |
| outHit | output | 1 | Registered hit indication |
| outMiss | output | 1 | Registered miss indication |
| outMulti | output | 1 | More than one entry matched |
| outPaddr | output | 32 | Translated physical address, 0 on a miss |
| outCached | output | 1 | Cacheability of the hit, 0 on a miss |

## Verification
The bench builds the block with the package defaults: 16 entries, 20-bit page numbers and 8-bit identifiers. With these values it can write both end indices, 0 and 15, including an all-ones page and frame at index 15. They also allow two overlapping entries at indices 2 and 9, to test priority and then fall back to the higher index once the lower one is invalidated. Both page sizes are mixed in the same array, so the bench can show that a large page ignores the low page-number bits it stores. Finally, a write is issued in the same cycle as a lookup of the page being written, to show that the old contents apply.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_ENTRIES = 16;
  localparam int TLB_IDX_W   = $clog2(TLB_ENTRIES);
  localparam int VA_W        = 32;
  localparam int ASID_W      = 8;
  localparam int SMALL_OFF_W = 12;
  localparam int BIG_OFF_W   = 24;
  localparam int VPN_W       = VA_W - SMALL_OFF_W;
  localparam int BIG_VPN_W   = VA_W - BIG_OFF_W;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              isGlobal;
    logic              big;
    logic [VPN_W-1:0]  pfn;
    logic              cached;
  } tlbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [TLB_ENTRIES-1:0] wrStrobe;
    logic [TLB_IDX_W-1:0]   selIdx;
    logic                   anyMatch;
    logic                   multiMatch;
  } ctrlStrobes_t;
endpackage

// File: rtl/tlb_xlate_ctrl.sv
module tlb_xlate_ctrl
  import tlb_pkg::*;
(
  input  logic                   wrEn,
  input  logic [TLB_IDX_W-1:0]   wrIdx,
  input  logic [TLB_ENTRIES-1:0] matchVec,
  output ctrlStrobes_t           strobes
);
  logic [TLB_ENTRIES-1:0] wrOneHot;
  logic [TLB_IDX_W-1:0]   firstIdx;

  always_comb begin
    wrOneHot = '0;
    if (wrEn) wrOneHot[wrIdx] = 1'b1;
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    firstIdx = '0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) firstIdx = TLB_IDX_W'(i);
    end
  end

  assign strobes.wrStrobe   = wrOneHot;
  assign strobes.selIdx     = firstIdx;
  assign strobes.anyMatch   = |matchVec;
  assign strobes.multiMatch = |(matchVec & (matchVec - TLB_ENTRIES'(1)));
endmodule

// File: rtl/tlb_xlate_dp.sv
module tlb_xlate_dp
  import tlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [VA_W-1:0]        vaddr,
  input  logic [ASID_W-1:0]      asid,
  input  tlbEntry_t              wrEntry,
  input  ctrlStrobes_t           strobes,
  output logic [TLB_ENTRIES-1:0] matchVec,
  output logic                   outHit,
  output logic                   outMiss,
  output logic                   outMulti,
  output logic [VA_W-1:0]        outPaddr,
  output logic                   outCached
);
  tlbEntry_t        entryQ [TLB_ENTRIES];
  tlbEntry_t        selEntry;
  logic [VA_W-1:0]  xlatAddr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (!rstN) entryQ[i] <= '0;
      else if (strobes.wrStrobe[i]) entryQ[i] <= wrEntry;
    end
  end

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : g_cmp
    logic vpnOk;
    logic asidOk;
    assign vpnOk  = entryQ[g].big
                  ? (entryQ[g].vpn[VPN_W-1 -: BIG_VPN_W] == vaddr[VA_W-1 -: BIG_VPN_W])
                  : (entryQ[g].vpn == vaddr[VA_W-1 -: VPN_W]);
    assign asidOk = entryQ[g].isGlobal || (entryQ[g].asid == asid);
    assign matchVec[g] = entryQ[g].valid && vpnOk && asidOk;
  end

  assign selEntry = entryQ[strobes.selIdx];
  assign xlatAddr = selEntry.big
                  ? {selEntry.pfn[VPN_W-1 -: BIG_VPN_W], vaddr[BIG_OFF_W-1:0]}
                  : {selEntry.pfn, vaddr[SMALL_OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outHit    <= 1'b0;
      outMiss   <= 1'b0;
      outMulti  <= 1'b0;
      outPaddr  <= '0;
      outCached <= 1'b0;
    end else begin
      outHit    <= strobes.anyMatch;
      outMiss   <= !strobes.anyMatch;
      outMulti  <= strobes.multiMatch;
      outPaddr  <= strobes.anyMatch ? xlatAddr : '0;
      outCached <= strobes.anyMatch && selEntry.cached;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VA_W-1:0]      vaddr,
  input  logic [ASID_W-1:0]    asid,
  input  logic                 wrEn,
  input  logic [TLB_IDX_W-1:0] wrIdx,
  input  logic                 wrValid,
  input  logic [VPN_W-1:0]     wrVpn,
  input  logic [ASID_W-1:0]    wrAsid,
  input  logic                 wrGlobal,
  input  logic                 wrBig,
  input  logic [VPN_W-1:0]     wrPfn,
  input  logic                 wrCached,
  output logic                 outHit,
  output logic                 outMiss,
  output logic                 outMulti,
  output logic [VA_W-1:0]      outPaddr,
  output logic                 outCached
);
  tlbEntry_t              wrEntry;
  ctrlStrobes_t           strobes;
  logic [TLB_ENTRIES-1:0] matchVec;

  assign wrEntry = '{valid: wrValid, vpn: wrVpn, asid: wrAsid, isGlobal: wrGlobal,
                     big: wrBig, pfn: wrPfn, cached: wrCached};

  tlb_xlate_ctrl ctrl_i (
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .matchVec (matchVec),
    .strobes  (strobes)
  );

  tlb_xlate_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .vaddr     (vaddr),
    .asid      (asid),
    .wrEntry   (wrEntry),
    .strobes   (strobes),
    .matchVec  (matchVec),
    .outHit    (outHit),
    .outMiss   (outMiss),
    .outMulti  (outMulti),
    .outPaddr  (outPaddr),
    .outCached (outCached)
  );
endmodule

// File: rtl/tlb_xlate_checker.sv
module tlb_xlate_checker
  import tlb_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [VA_W-1:0] vaddr,
  input logic            wrEn,
  input logic            wrValid,
  input logic            outHit,
  input logic            outMiss,
  input logic            outMulti,
  input logic [VA_W-1:0] outPaddr,
  input logic            outCached
);
  logic anyWritten;
  logic sawClock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      anyWritten <= 1'b0;
      sawClock   <= 1'b0;
    end else begin
      sawClock <= 1'b1;
      if (wrEn && wrValid) anyWritten <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!outHit && !outMiss && !outMulti && outPaddr == '0 && !outCached));

  assert_cold_miss_R1: assert property (@(posedge clk) disable iff (!rstN)
    !anyWritten |-> !outHit);

  assert_hit_miss_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    sawClock |-> (outHit != outMiss));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    outMiss |-> (outPaddr == '0 && !outCached && !outMulti));

  assert_multi_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    outMulti |-> outHit);

  assert_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sawClock && outHit) |-> outPaddr[SMALL_OFF_W-1:0] == $past(vaddr[SMALL_OFF_W-1:0]));
endmodule

bind tlb_xlate tlb_xlate_checker chk_i (.*);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vaddr = '0;
  logic [7:0]  asid = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic        wrValid = 1'b0;
  logic [19:0] wrVpn = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic        wrBig = 1'b0;
  logic [19:0] wrPfn = '0;
  logic        wrCached = 1'b0;
  logic        outHit, outMiss, outMulti, outCached;
  logic [31:0] outPaddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_xlate dut_i (.*);

  // reference model
  bit          mValid [16];
  logic [19:0] mVpn   [16];
  logic [7:0]  mAsid  [16];
  bit          mGlob  [16];
  bit          mBig   [16];
  logic [19:0] mPfn   [16];
  bit          mCach  [16];

  typedef struct {
    bit          chk;
    bit          hit;
    bit          multi;
    bit          cached;
    logic [31:0] paddr;
    string       req;
  } expItem_t;
  expItem_t scoreQ[$];

  function automatic expItem_t predict(logic [31:0] va, logic [7:0] as, string req);
    expItem_t e;
    int n = 0;
    e.chk = 1; e.hit = 0; e.multi = 0; e.cached = 0; e.paddr = '0; e.req = req;
    for (int i = 0; i < 16; i++) begin
      bit pg;
      pg = mBig[i] ? (mVpn[i][19:12] == va[31:24]) : (mVpn[i] == va[31:12]);
      if (mValid[i] && pg && (mGlob[i] || mAsid[i] == as)) begin
        if (n == 0) begin
          e.hit = 1;
          e.cached = mCach[i];
          e.paddr = mBig[i] ? {mPfn[i][19:12], va[23:0]} : {mPfn[i], va[11:0]};
        end
        n++;
      end
    end
    e.multi = (n > 1);
    return e;
  endfunction

  // pending write applied on the next step
  bit          pEn;
  logic [3:0]  pIdx;
  bit          pValid, pGlob, pBig, pCach;
  logic [19:0] pVpn, pPfn;
  logic [7:0]  pAsid;

  task automatic step(input logic [31:0] va, input logic [7:0] as, input bit chk, input string req);
    expItem_t e;
    @(negedge clk);
    e = predict(va, as, req);
    e.chk = chk;
    scoreQ.push_back(e);
    vaddr = va; asid = as;
    wrEn = pEn; wrIdx = pIdx; wrValid = pValid; wrVpn = pVpn; wrAsid = pAsid;
    wrGlobal = pGlob; wrBig = pBig; wrPfn = pPfn; wrCached = pCach;
    if (pEn) begin
      mValid[pIdx] = pValid; mVpn[pIdx] = pVpn; mAsid[pIdx] = pAsid; mGlob[pIdx] = pGlob;
      mBig[pIdx] = pBig; mPfn[pIdx] = pPfn; mCach[pIdx] = pCach;
    end
    pEn = 0;
  endtask

  task automatic writeEntry(input logic [3:0] idx, input bit v, input logic [19:0] vpn,
                            input logic [7:0] as, input bit g, input bit big,
                            input logic [19:0] pfn, input bit c);
    pEn = 1; pIdx = idx; pValid = v; pVpn = vpn; pAsid = as; pGlob = g;
    pBig = big; pPfn = pfn; pCach = c;
    step(32'h0, 8'h0, 0, "");
  endtask

  // monitor: compares each result one cycle after its inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        if (e.chk) begin
          checks++;
          if (outHit !== e.hit || outMiss !== !e.hit || outMulti !== e.multi ||
              outCached !== e.cached || outPaddr !== e.paddr) begin
            errors++;
            $display("FAIL %s: hit=%b miss=%b multi=%b cached=%b paddr=%h expected hit=%b miss=%b multi=%b cached=%b paddr=%h",
                     e.req, outHit, outMiss, outMulti, outCached, outPaddr,
                     e.hit, !e.hit, e.multi, e.cached, e.paddr);
          end
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mValid[i] = 0;
    pEn = 0;
    vaddr = 32'hDEADBEEF;
    wrEn = 1'b1; wrValid = 1'b1; wrGlobal = 1'b1; wrIdx = 4'd1;
    repeat (4) @(negedge clk);
    checks++;  // R1 outputs zero during reset
    if (outHit !== 0 || outMiss !== 0 || outMulti !== 0 || outPaddr !== 0 || outCached !== 0) begin
      errors++;
      $display("FAIL R1 reset: hit=%b miss=%b multi=%b paddr=%h cached=%b expected all 0",
               outHit, outMiss, outMulti, outPaddr, outCached);
    end
    wrEn = 1'b0;
    rstN = 1'b1;

    step(32'hDEADBEEF, 8'h00, 1, "R1 cold lookup misses");
    step(32'h12345678, 8'h22, 1, "R1 cold lookup misses");

    writeEntry(4'd3, 1, 20'h12345, 8'h22, 0, 0, 20'hABCDE, 1);
    step(32'h12345678, 8'h22, 1, "R2 R5 R6 small page hit");
    step(32'h12345678, 8'h23, 1, "R3 identifier mismatch misses");
    step(32'h12346678, 8'h22, 1, "R2 neighbouring page misses");

    writeEntry(4'd5, 1, 20'h00400, 8'h01, 1, 0, 20'h00077, 0);
    step(32'h00400F0F, 8'hC3, 1, "R3 global entry any identifier");
    step(32'h00400001, 8'h01, 1, "R6 uncached hit");

    writeEntry(4'd7, 1, 20'h80FFF, 8'h22, 0, 1, 20'h1F123, 1);
    step(32'h80ABCDEF, 8'h22, 1, "R4 big page hit");
    step(32'h80000000, 8'h22, 1, "R4 big page ignores low page bits");
    step(32'h80ABCDEF, 8'h30, 1, "R3 R4 big page identifier mismatch");
    step(32'h81000000, 8'h22, 1, "R4 big page other region misses");

    writeEntry(4'd9, 1, 20'h55555, 8'h00, 1, 0, 20'h99999, 0);
    writeEntry(4'd2, 1, 20'h55555, 8'h00, 1, 0, 20'h22222, 1);
    step(32'h55555123, 8'h44, 1, "R8 lowest index wins with multi flag");
    writeEntry(4'd2, 0, 20'h55555, 8'h00, 1, 0, 20'h22222, 1);
    step(32'h55555123, 8'h44, 1, "R10 R8 invalidated entry falls back");

    pEn = 1; pIdx = 4'd11; pValid = 1; pVpn = 20'h0BEEF; pAsid = 8'h00;
    pGlob = 1; pBig = 0; pPfn = 20'h0CAFE; pCach = 1;
    step(32'h0BEEF010, 8'h00, 1, "R9 lookup in write cycle sees old contents");
    step(32'h0BEEF010, 8'h00, 1, "R9 write visible next cycle");

    writeEntry(4'd0, 1, 20'h00001, 8'h01, 0, 0, 20'h00010, 1);
    writeEntry(4'd15, 1, 20'hFFFFF, 8'h00, 1, 0, 20'hFFFFF, 0);
    step(32'h00001ABC, 8'h01, 1, "R5 index 0 entry");
    step(32'hFFFFFFFF, 8'h7E, 1, "R5 index 15 all-ones entry");

    writeEntry(4'd3, 0, 20'h12345, 8'h22, 0, 0, 20'hABCDE, 1);
    step(32'h12345678, 8'h22, 1, "R10 invalidated small entry misses");
    step(32'h12345678, 8'h22, 0, "");

    repeat (4) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule